// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

This block moves data between one narrow port (A) and a wide side made of two equal halves (1B and 2B) that together carry twice the narrow width. Going from A to the wide side, two narrow words that arrive one after the other are gathered and then presented together as a single wide word. The 1B half sits behind two register stages and the 2B half behind one. With its own enable for each half, the first word can be parked in the deeper path while the second word loads straight into 2B. Going from the wide side to A, each half is captured in its own register under its own enable, and a select line chooses which stored half is driven back onto A.

Every register group has an active-low clock enable and updates only on the rising clock edge. The two port output enables are active low and pass through a register, so a change of bus direction takes effect on a clock edge. No tri-state nets are modelled. Each port has a data output and a separate drive flag, and both sides may drive at the same time. An optional synchronous reset turns both drive flags off. It leaves the data registers untouched.

Top module: `nw_bus_exchanger`

## Requirements
- R1: A register group whose active-low enable is high at a rising edge keeps its stored value. This covers the 1B pipeline, the 2B register and either return capture register, and the output that register feeds stays stable.
- R2: The A-to-1B path is a two-stage pipeline that advances only when `a1_hold_n` is low. A word applied on `a_in` at such an edge reaches `b1_out` after the second such edge, not after the first.
- R3: The A-to-2B path is a single register. When `a2_hold_n` is low at an edge, `b2_out` equals the `a_in` of that edge from the edge onward.
- R4: Loading word W0 with `a1_hold_n`=0 and `a2_hold_n`=1, then word W1 with both low, leaves `b1_out`=W0 and `b2_out`=W1 in the same cycle.
- R5: With `a1_hold_n`=1 and `a2_hold_n`=0, only 2B takes the new A word. Both 1B stages hold, so a word parked in the first stage reaches `b1_out` unchanged at the next advance.
- R6: `b1_in` is captured when `r1_hold_n` is low and `b2_in` is captured when `r2_hold_n` is low. Each capture is independent of the other.
- R7: `a_out` shows the stored 1B capture when `sel_1b`=1 and the stored 2B capture when `sel_1b`=0. The select takes effect without a clock edge.
- R8: `a_drive` equals the inverse of `oe_a_n` as sampled at the most recent rising edge, and `b_drive` likewise follows `oe_b_n`. This gives one edge of latency, and the two ports are independent, so both may drive together.
- R9: With `HAS_RST`=1, `rst` high at a rising edge clears `a_drive` and `b_drive` whatever the enable inputs are. The data outputs are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset of the registered drive flags, active high |
| a_in | input | W | Narrow-side word toward the wide side |
| b1_in | input | W | 1B half returning to the narrow side |
| b2_in | input | W | 2B half returning to the narrow side |
| sel_1b | input | 1 | 1 returns the 1B capture on A, 0 returns the 2B capture |
| oe_a_n | input | 1 | Narrow-port output enable, active low, registered |
| oe_b_n | input | 1 | Wide-port output enable, active low, registered |
| a1_hold_n | input | 1 | Active-low enable of the two-stage A-to-1B pipeline |
| a2_hold_n | input | 1 | Active-low enable of the A-to-2B register |
| r1_hold_n | input | 1 | Active-low enable of the 1B return capture |
| r2_hold_n | input | 1 | Active-low enable of the 2B return capture |
| a_out | output | W | Data presented on the narrow port |
| a_drive | output | 1 | Narrow port drives when 1 |
| b1_out | output | W | Data presented on the 1B half |
| b2_out | output | W | Data presented on the 2B half |
| b_drive | output | 1 | Both wide halves drive when 1 |

## Verification
The bench builds the block with its defaults: a 12-bit word and `HAS_RST`=1. At that width, word values such as 0x123 and 0x456 keep every pipeline stage distinguishable, so a slip of one stage in the 1B path or a lost parked word shows up as a wrong value. Because the reset variant is present, the bench can force both drive flags off while the enable inputs request driving, and it can then confirm that the data registers kept their contents.

// File: rtl/xch_pkg.sv
package xch_pkg;

  // Which stored wide-side half is returned to the narrow port.
  typedef enum logic {
    RET_2B = 1'b0,
    RET_1B = 1'b1
  } ret_sel_e;

  // Active-low enable to active-high drive flag.
  function automatic logic drive_of(input logic en_n);
    return ~en_n;
  endfunction

  // Active-low register enable to load strobe.
  function automatic logic load_of(input logic hold_n);
    return ~hold_n;
  endfunction

  // Map the raw select pin onto the return choice.
  function automatic ret_sel_e ret_of(input logic sel_1b);
    return sel_1b ? RET_1B : RET_2B;
  endfunction

endpackage

// File: rtl/xch_a2b_path.sv
module xch_a2b_path
  import xch_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic         a1_hold_n,
  input  logic         a2_hold_n,
  output logic [W-1:0] b1_q,
  output logic [W-1:0] b2_q
);

  localparam int NSTG = 2;

  logic         adv_1b;
  logic         load_2b;
  logic [W-1:0] stg_q [NSTG];

  assign adv_1b  = load_of(a1_hold_n);
  assign load_2b = load_of(a2_hold_n);

  // 1B pipeline: every stage advances together on the 1B enable only.
  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (adv_1b) stg_q[0] <= a_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (adv_1b) stg_q[s] <= stg_q[s-1];
      end
    end
  end

  // 2B single register.
  logic [W-1:0] b2_r;
  always_ff @(posedge clk) begin
    if (load_2b) b2_r <= a_in;
  end

  assign b1_q = stg_q[NSTG-1];
  assign b2_q = b2_r;

  // R1 / R5: a held 1B enable freezes the output half
  a_r1_b1_hold : assert property (@(posedge clk) disable iff (rst)
    a1_hold_n |=> $stable(b1_q));

  // R1: a held 2B enable freezes 2B
  a_r1_b2_hold : assert property (@(posedge clk) disable iff (rst)
    a2_hold_n |=> $stable(b2_q));

  // R3: single-edge latency into 2B
  a_r3_b2_load : assert property (@(posedge clk) disable iff (rst)
    !a2_hold_n |=> (b2_q == $past(a_in)));

  // R2: two consecutive advances carry a word from A to 1B
  a_r2_b1_two_edges : assert property (@(posedge clk) disable iff (rst)
    (!a1_hold_n && $past(!a1_hold_n) && !$past(rst)) |=> (b1_q == $past(a_in, 2)));

endmodule

// File: rtl/xch_b2a_path.sv
module xch_b2a_path
  import xch_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] b1_in,
  input  logic [W-1:0] b2_in,
  input  logic         r1_hold_n,
  input  logic         r2_hold_n,
  input  logic         sel_1b,
  output logic [W-1:0] a_q
);

  localparam int NHALF = 2;

  logic [W-1:0] cap_d [NHALF];
  logic         cap_en [NHALF];
  logic [W-1:0] cap_q [NHALF];

  assign cap_d[0]  = b1_in;
  assign cap_d[1]  = b2_in;
  assign cap_en[0] = load_of(r1_hold_n);
  assign cap_en[1] = load_of(r2_hold_n);

  for (genvar h = 0; h < NHALF; h++) begin : g_cap
    always_ff @(posedge clk) begin
      if (cap_en[h]) cap_q[h] <= cap_d[h];
    end

    // R6: enabled capture takes the half presented at the edge
    a_r6_capture : assert property (@(posedge clk) disable iff (rst)
      cap_en[h] |=> (cap_q[h] == $past(cap_d[h])));

    // R1: disabled capture keeps its value
    a_r1_cap_hold : assert property (@(posedge clk) disable iff (rst)
      !cap_en[h] |=> $stable(cap_q[h]));
  end

  ret_sel_e pick;
  assign pick = ret_of(sel_1b);
  assign a_q  = (pick == RET_1B) ? cap_q[0] : cap_q[1];

  // R7: with no capture and a steady select the returned word is steady
  a_r7_ret_steady : assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(sel_1b) && !$past(cap_en[0]) && !$past(cap_en[1]))
      |-> $stable(a_q));

endmodule

// File: rtl/xch_oe_sync.sv
module xch_oe_sync
  import xch_pkg::*;
#(
  parameter int  NPORT   = 2,
  parameter bit  HAS_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] oe_n,
  output logic [NPORT-1:0] drive
);

  logic [NPORT-1:0] oe_q;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    if (HAS_RST) begin : g_rst
      always_ff @(posedge clk) begin
        if (rst) oe_q[p] <= 1'b1;
        else     oe_q[p] <= oe_n[p];
      end

      // R9: reset turns drive off on the next edge
      a_r9_reset_off : assert property (@(posedge clk)
        $past(rst) |-> !drive[p]);
    end else begin : g_norst
      always_ff @(posedge clk) begin
        oe_q[p] <= oe_n[p];
      end
    end

    assign drive[p] = drive_of(oe_q[p]);

    // R8: drive reflects the enable sampled one edge earlier
    a_r8_oe_latency : assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (drive[p] == !$past(oe_n[p])));
  end

endmodule

// File: rtl/nw_bus_exchanger.sv
module nw_bus_exchanger
  import xch_pkg::*;
#(
  parameter int W       = 12,
  parameter bit HAS_RST = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b1_in,
  input  logic [W-1:0] b2_in,
  input  logic         sel_1b,
  input  logic         oe_a_n,
  input  logic         oe_b_n,
  input  logic         a1_hold_n,
  input  logic         a2_hold_n,
  input  logic         r1_hold_n,
  input  logic         r2_hold_n,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  output logic [W-1:0] b1_out,
  output logic [W-1:0] b2_out,
  output logic         b_drive
);

  localparam int PORT_A = 0;
  localparam int PORT_B = 1;
  localparam int NPORT  = 2;

  logic             rst_eff;
  logic [NPORT-1:0] oe_n_vec;
  logic [NPORT-1:0] drive_vec;

  assign rst_eff = HAS_RST ? rst : 1'b0;

  xch_a2b_path #(.W(W)) u_a2b (
    .clk       (clk),
    .rst       (rst_eff),
    .a_in      (a_in),
    .a1_hold_n (a1_hold_n),
    .a2_hold_n (a2_hold_n),
    .b1_q      (b1_out),
    .b2_q      (b2_out)
  );

  xch_b2a_path #(.W(W)) u_b2a (
    .clk       (clk),
    .rst       (rst_eff),
    .b1_in     (b1_in),
    .b2_in     (b2_in),
    .r1_hold_n (r1_hold_n),
    .r2_hold_n (r2_hold_n),
    .sel_1b    (sel_1b),
    .a_q       (a_out)
  );

  assign oe_n_vec[PORT_A] = oe_a_n;
  assign oe_n_vec[PORT_B] = oe_b_n;

  xch_oe_sync #(.NPORT(NPORT), .HAS_RST(HAS_RST)) u_oe (
    .clk   (clk),
    .rst   (rst_eff),
    .oe_n  (oe_n_vec),
    .drive (drive_vec)
  );

  assign a_drive = drive_vec[PORT_A];
  assign b_drive = drive_vec[PORT_B];

  // R8: the two ports are independent, so both drive after both enables were low
  a_r8_both_ports : assert property (@(posedge clk) disable iff (rst_eff)
    (!$past(rst_eff) && !$past(oe_a_n) && !$past(oe_b_n)) |-> (a_drive && b_drive));

  // R9: reset leaves the wide-side data untouched
  a_r9_data_kept : assert property (@(posedge clk)
    ($past(rst_eff) && $past(a1_hold_n) && $past(a2_hold_n))
      |-> ($stable(b1_out) && $stable(b2_out)));

endmodule

// File: tb/nw_bus_exchanger_tb.sv
module nw_bus_exchanger_tb;

  localparam int W   = 12;
  localparam int PER = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_in, b1_in, b2_in;
  logic         sel_1b, oe_a_n, oe_b_n;
  logic         a1_hold_n, a2_hold_n, r1_hold_n, r2_hold_n;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic         a_drive, b_drive;

  always #(PER/2) clk = ~clk;

  nw_bus_exchanger #(.W(W), .HAS_RST(1'b1)) u_dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b1_in(b1_in), .b2_in(b2_in),
    .sel_1b(sel_1b), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .a1_hold_n(a1_hold_n), .a2_hold_n(a2_hold_n),
    .r1_hold_n(r1_hold_n), .r2_hold_n(r2_hold_n),
    .a_out(a_out), .a_drive(a_drive), .b1_out(b1_out), .b2_out(b2_out),
    .b_drive(b_drive)
  );

  typedef struct packed {
    logic [W-1:0] a, b1, b2;
    logic sel, oea_n, oeb_n, h1_n, h2_n, r1_n, r2_n;
    logic [W-1:0] e_b1, e_b2, e_a;
    logic e_ad, e_bd;
  } vec_t;

  // Expected values are after the edge at which the vector is applied.
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    // a      b1      b2      sel  oea  oeb  h1   h2   r1   r2   e_b1    e_b2    e_a     ad   bd
    '{12'h123,12'h000,12'h000,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,12'h000,12'h000,12'h000,1'b1,1'b0},
    '{12'h456,12'h000,12'h000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,12'h123,12'h456,12'h000,1'b1,1'b1},
    '{12'h789,12'h000,12'h000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,12'h123,12'h789,12'h000,1'b0,1'b1},
    '{12'hABC,12'h321,12'h654,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,12'h123,12'h789,12'h321,1'b1,1'b0},
    '{12'hDEF,12'h111,12'h222,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,12'h456,12'h789,12'h222,1'b1,1'b1},
    '{12'h000,12'hFFF,12'hFFF,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,12'hDEF,12'h789,12'h321,1'b0,1'b1},
    '{12'hFFF,12'hFFF,12'hFFF,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,12'hDEF,12'h789,12'h222,1'b1,1'b0},
    '{12'hC3C,12'hA5A,12'h5A5,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,12'h000,12'hC3C,12'h5A5,1'b0,1'b0}
  };

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive_in(input vec_t v);
    a_in = v.a; b1_in = v.b1; b2_in = v.b2; sel_1b = v.sel;
    oe_a_n = v.oea_n; oe_b_n = v.oeb_n;
    a1_hold_n = v.h1_n; a2_hold_n = v.h2_n;
    r1_hold_n = v.r1_n; r2_hold_n = v.r2_n;
  endtask

  // Apply at the falling edge, check a quarter period after the rising edge.
  task automatic edge_then_sample();
    @(posedge clk);
    #(PER/4);
  endtask

  initial begin
    rst = 1'b1;
    a_in = '0; b1_in = '0; b2_in = '0; sel_1b = 1'b1;
    oe_a_n = 1'b0; oe_b_n = 1'b0;
    a1_hold_n = 1'b1; a2_hold_n = 1'b1; r1_hold_n = 1'b1; r2_hold_n = 1'b1;
    repeat (3) edge_then_sample();
    // R9: reset state, drives off although both enables are low
    chk("R9", "a_drive at reset", {11'd0, a_drive}, 12'd0);
    chk("R9", "b_drive at reset", {11'd0, b_drive}, 12'd0);

    // Prelude: flush every data register to zero, drives stay off.
    @(negedge clk);
    rst = 1'b0; oe_a_n = 1'b1; oe_b_n = 1'b1;
    a1_hold_n = 1'b0; a2_hold_n = 1'b0; r1_hold_n = 1'b0; r2_hold_n = 1'b0;
    repeat (2) edge_then_sample();

    // Vector table: R1 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive_in(VECS[i]);
      edge_then_sample();
      chk((i == 1) ? "R4" : "R2/R5", $sformatf("v%0d b1_out", i), b1_out, VECS[i].e_b1);
      chk("R3", $sformatf("v%0d b2_out", i), b2_out, VECS[i].e_b2);
      chk("R7", $sformatf("v%0d a_out", i), a_out, VECS[i].e_a);
      chk("R8", $sformatf("v%0d a_drive", i), {11'd0, a_drive}, {11'd0, VECS[i].e_ad});
      chk("R8", $sformatf("v%0d b_drive", i), {11'd0, b_drive}, {11'd0, VECS[i].e_bd});
    end
    // Now: stage1=C3C, b1=000, b2=C3C, cap1=A5A, cap2=5A5.

    // R7: select switches the return word with no clock edge
    @(negedge clk);
    a1_hold_n = 1'b1; a2_hold_n = 1'b1; r1_hold_n = 1'b1; r2_hold_n = 1'b1;
    sel_1b = 1'b1;
    #1 chk("R7", "sel=1 mid-cycle", a_out, 12'hA5A);
    sel_1b = 1'b0;
    #1 chk("R7", "sel=0 mid-cycle", a_out, 12'h5A5);

    // R2: a word needs two advancing edges to reach 1B
    @(negedge clk);
    a_in = 12'h777; a1_hold_n = 1'b0;
    edge_then_sample();
    chk("R2", "b1 after first edge", b1_out, 12'hC3C);
    @(negedge clk);
    a_in = 12'h888;
    edge_then_sample();
    chk("R2", "b1 after second edge", b1_out, 12'h777);
    chk("R1", "b2 held by its enable", b2_out, 12'hC3C);

    // R1: long hold with changing inputs
    @(negedge clk);
    a1_hold_n = 1'b1; a2_hold_n = 1'b1; r1_hold_n = 1'b1; r2_hold_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      a_in = 12'(k * 12'h111); b1_in = ~a_in; b2_in = a_in ^ 12'h0F0;
      edge_then_sample();
      @(negedge clk);
    end
    chk("R1", "b1 after hold run", b1_out, 12'h777);
    chk("R1", "b2 after hold run", b2_out, 12'hC3C);
    chk("R1", "a_out after hold run", a_out, 12'h5A5);

    // R8: both ports drive together
    oe_a_n = 1'b0; oe_b_n = 1'b0;
    edge_then_sample();
    chk("R8", "a_drive both", {11'd0, a_drive}, 12'd1);
    chk("R8", "b_drive both", {11'd0, b_drive}, 12'd1);

    // R9: synchronous reset overrides, data kept
    @(negedge clk);
    rst = 1'b1;
    #1 chk("R9", "a_drive before reset edge", {11'd0, a_drive}, 12'd1);
    edge_then_sample();
    chk("R9", "a_drive after reset edge", {11'd0, a_drive}, 12'd0);
    chk("R9", "b_drive after reset edge", {11'd0, b_drive}, 12'd0);
    chk("R9", "b1 kept across reset", b1_out, 12'h777);
    chk("R9", "b2 kept across reset", b2_out, 12'hC3C);
    @(negedge clk);
    rst = 1'b0;
    edge_then_sample();
    chk("R8", "a_drive resumes", {11'd0, a_drive}, 12'd1);
    chk("R8", "b_drive resumes", {11'd0, b_drive}, 12'd1);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(PER * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule